// File: doc/BRIEF.md
# Indirect Configuration and I/O Port Access Window

This block lets a CPU reach a downstream bus's configuration space and I/O-port space through a small register window. The CPU writes a target address into a single latch register. It then reads or writes one of two data windows. An access to the config window becomes a configuration cycle and an access to the I/O window becomes an I/O-port cycle. The byte enables of the access choose the lanes, and the window that was hit chooses the cycle type.

The slave side is a plain memory-mapped port. The requester holds its read or write strobe until `s_ready` pulses. A window access stalls the requester until the downstream side answers with `d_ready`. Read data comes back positioned in its own lanes. A downstream error is absorbed: a read returns all ones, and the failure is recorded in a sticky status bit.

Top module: `cfgio_window`

## Requirements
- R1: The address latch sits at byte offset 0x064, resets to zero, and can be read back. A write updates only the bytes whose enables are set. A write to the latch never starts a downstream cycle.
- R2: A read of the config window at offset 0x068 issues exactly one downstream cycle of type code 0 (config read). Its address is latch bits 31:2 followed by the lane offset.
- R3: A write of the config window issues one cycle of type code 1 (config write), carrying the slave write data and byte enables unchanged.
- R4: Accesses to the I/O window at offset 0x06C issue type code 2 (read) or 3 (write). The address is latch bits 15:2 followed by the lane offset, and bits 31:16 are zero.
- R5: The slave byte enables must be contiguous: one lane, an aligned half, or all four. Downstream address bits 1:0 equal the index of the lowest enabled lane, and `d_be` equals `s_be`. Slave address bits 1:0 are ignored when decoding.
- R6: Read data is returned only in the enabled lanes, and the disabled lanes read as zero.
- R7: `d_req` rises on the clock edge after a window access is seen, and it holds stable with its fields until `d_ready`. `s_ready` pulses for one cycle on the edge where `d_ready` is sampled, and never earlier.
- R8: If `d_err` accompanies `d_ready`, a read returns 0xFFFFFFFF and a write is dropped. In both cases bit 0 of the status register at offset 0x070 is set and stays set. Writing 1 to that bit clears it.
- R9: Every window access produces exactly one downstream cycle. This holds for back-to-back latch writes with dummy config reads in between, where each read is a real config read.
- R10: Any other offset reads as zero and ignores writes. A register access, including one to an unused offset, is acknowledged on the edge after the strobe is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_addr | input | 12 | Slave byte address |
| s_rd | input | 1 | Slave read strobe, held until s_ready |
| s_wr | input | 1 | Slave write strobe, held until s_ready |
| s_be | input | 4 | Slave byte enables |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data, valid with s_ready |
| s_ready | output | 1 | One-cycle completion pulse |
| d_req | output | 1 | Downstream cycle request |
| d_type | output | 2 | Cycle type: 0 config read, 1 config write, 2 I/O read, 3 I/O write |
| d_addr | output | 32 | Downstream cycle address |
| d_be | output | 4 | Downstream byte enables |
| d_wdata | output | 32 | Downstream write data |
| d_ready | input | 1 | Downstream completion, sampled while d_req is high |
| d_err | input | 1 | Downstream error, valid with d_ready |
| d_rdata | input | 32 | Downstream read data, valid with d_ready |

## Verification
A register access is answered one edge after its strobe is seen. A window access raises `d_req` one edge after its strobe. Its completion arrives one edge after the edge where `d_ready` is sampled, and a status update lands on that same edge. The bench drives and samples on the falling edge. It checks the downstream request fields on the first falling edge after the strobe, and it compares them against its own model on every clock while `d_req` is high. It takes read data only on the falling edge where `s_ready` is first seen, and it flags any completion that arrives before a response was supplied. Response delays of 1, 2 and 20 cycles are used so that the stall is observed across several waits.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  typedef enum logic [1:0] {
    CYC_CFG_RD = 2'd0,
    CYC_CFG_WR = 2'd1,
    CYC_IO_RD  = 2'd2,
    CYC_IO_WR  = 2'd3
  } cyc_t;
endpackage

// File: rtl/cfgio_lane_pick.sv
// Index of the lowest enabled byte lane (R5).
module cfgio_lane_pick #(
  parameter int NB = 4,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic [NB-1:0]    be,
  output logic [OFS_W-1:0] ofs
);
  always_comb begin
    ofs = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (be[i]) ofs = OFS_W'(i);
    end
  end
endmodule

// File: rtl/cfgio_rd_steer.sv
// Keeps enabled lanes of returned data, zeroes the rest, forces ones on error.
module cfgio_rd_steer #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic [NB-1:0]     be,
  input  logic              err,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] mask;
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign mask[g*8 +: 8] = {8{be[g]}};
  end
  assign dout = err ? '1 : (din & mask);
endmodule

// File: rtl/cfgio_ctrl.sv
module cfgio_ctrl
  import cfgio_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int IO_W     = 16,
  parameter int LATCH_OFS = 'h064,
  parameter int CFG_OFS  = 'h068,
  parameter int IO_OFS   = 'h06C,
  parameter int STAT_OFS = 'h070,
  localparam int NB = DATA_W / 8,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              s_rd,
  input  logic              s_wr,
  input  logic [NB-1:0]     s_be,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_ready,
  output logic              d_req,
  output cyc_t              d_type,
  output logic [DATA_W-1:0] d_addr,
  output logic [NB-1:0]     d_be,
  output logic [DATA_W-1:0] d_wdata,
  input  logic              d_ready,
  input  logic              d_err,
  input  logic [OFS_W-1:0]  lane_ofs,
  input  logic [DATA_W-1:0] steered
);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(LATCH_OFS);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] A_IO    = ADDR_W'(IO_OFS);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_OFS);

  logic [DATA_W-1:0] latch_q;
  logic              err_q;
  logic              hit_latch, hit_cfg, hit_io, hit_stat, go;

  assign hit_latch = s_addr[ADDR_W-1:OFS_W] == A_LATCH[ADDR_W-1:OFS_W];
  assign hit_cfg   = s_addr[ADDR_W-1:OFS_W] == A_CFG[ADDR_W-1:OFS_W];
  assign hit_io    = s_addr[ADDR_W-1:OFS_W] == A_IO[ADDR_W-1:OFS_W];
  assign hit_stat  = s_addr[ADDR_W-1:OFS_W] == A_STAT[ADDR_W-1:OFS_W];
  assign go        = (s_rd || s_wr) && !s_ready && !d_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      err_q   <= 1'b0;
      d_req   <= 1'b0;
      d_type  <= CYC_CFG_RD;
      d_addr  <= '0;
      d_be    <= '0;
      d_wdata <= '0;
      s_ready <= 1'b0;
      s_rdata <= '0;
    end else begin
      s_ready <= 1'b0;
      if (d_req) begin
        if (d_ready) begin
          d_req   <= 1'b0;
          s_ready <= 1'b1;
          s_rdata <= d_type[0] ? '0 : steered;
          if (d_err) err_q <= 1'b1;
        end
      end else if (go) begin
        if (hit_cfg || hit_io) begin
          d_req   <= 1'b1;
          d_type  <= hit_io ? (s_wr ? CYC_IO_WR : CYC_IO_RD)
                            : (s_wr ? CYC_CFG_WR : CYC_CFG_RD);
          d_addr  <= hit_io ? {{(DATA_W-IO_W){1'b0}}, latch_q[IO_W-1:OFS_W], lane_ofs}
                            : {latch_q[DATA_W-1:OFS_W], lane_ofs};
          d_be    <= s_be;
          d_wdata <= s_wdata;
        end else begin
          s_ready <= 1'b1;
          if (s_rd && hit_latch)     s_rdata <= latch_q;
          else if (s_rd && hit_stat) s_rdata <= {{(DATA_W-1){1'b0}}, err_q};
          else                       s_rdata <= '0;
          if (s_wr && hit_latch) begin
            for (int i = 0; i < NB; i++) begin
              if (s_be[i]) latch_q[i*8 +: 8] <= s_wdata[i*8 +: 8];
            end
          end
          if (s_wr && hit_stat && s_be[0] && s_wdata[0]) err_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cfgio_window.sv
module cfgio_window
  import cfgio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IO_W   = 16,
  localparam int NB = DATA_W / 8,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              s_rd,
  input  logic              s_wr,
  input  logic [NB-1:0]     s_be,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_ready,
  output logic              d_req,
  output logic [1:0]        d_type,
  output logic [DATA_W-1:0] d_addr,
  output logic [NB-1:0]     d_be,
  output logic [DATA_W-1:0] d_wdata,
  input  logic              d_ready,
  input  logic              d_err,
  input  logic [DATA_W-1:0] d_rdata
);
  logic [OFS_W-1:0]  lane_ofs;
  logic [DATA_W-1:0] steered;
  cyc_t              type_q;

  cfgio_lane_pick #(.NB(NB)) u_pick (.be(s_be), .ofs(lane_ofs));

  cfgio_rd_steer #(.DATA_W(DATA_W)) u_steer (
    .be(d_be), .err(d_err), .din(d_rdata), .dout(steered)
  );

  cfgio_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_W(IO_W)) u_ctrl (
    .clk(clk), .rst(rst), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr),
    .s_be(s_be), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ready(s_ready),
    .d_req(d_req), .d_type(type_q), .d_addr(d_addr), .d_be(d_be),
    .d_wdata(d_wdata), .d_ready(d_ready), .d_err(d_err),
    .lane_ofs(lane_ofs), .steered(steered)
  );

  assign d_type = type_q;
endmodule

// File: rtl/cfgio_window_chk.sv
module cfgio_window_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IO_W   = 16,
  localparam int NB = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] s_addr,
  input logic              s_rd,
  input logic              s_wr,
  input logic [NB-1:0]     s_be,
  input logic [DATA_W-1:0] s_rdata,
  input logic              s_ready,
  input logic              d_req,
  input logic [1:0]        d_type,
  input logic [DATA_W-1:0] d_addr,
  input logic [NB-1:0]     d_be,
  input logic [DATA_W-1:0] d_wdata,
  input logic              d_ready,
  input logic              d_err
);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'('h064);
  logic [DATA_W-1:0] be_mask;
  for (genvar g = 0; g < NB; g++) begin : g_m
    assign be_mask[g*8 +: 8] = {8{d_be[g]}};
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    d_req && !d_ready |=> d_req && $stable(d_type) && $stable(d_addr)
                          && $stable(d_be) && $stable(d_wdata));
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready);
  assert_ack_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
    d_req && d_ready |=> s_ready && !d_req);
  assert_latch_no_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    !d_req && !s_ready && s_wr && s_addr[ADDR_W-1:2] == A_LATCH[ADDR_W-1:2] |=> !d_req);
  assert_err_ones_R8: assert property (@(posedge clk) disable iff (rst)
    d_req && d_ready && d_err && !d_type[0] |=> s_rdata == '1);
  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
    d_req && d_ready && !d_err && !d_type[0] |=> (s_rdata & ~$past(be_mask)) == '0);
  assert_io_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    d_req && d_type[1] |-> d_addr[DATA_W-1:IO_W] == '0);
  assert_lane_R5: assert property (@(posedge clk) disable iff (rst)
    d_req |-> d_be[d_addr[1:0]] && ((d_be & ((NB'(1) << d_addr[1:0]) - NB'(1))) == '0));
endmodule

bind cfgio_window cfgio_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_W(IO_W)) u_chk (
  .clk(clk), .rst(rst), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr), .s_be(s_be),
  .s_rdata(s_rdata), .s_ready(s_ready), .d_req(d_req), .d_type(d_type),
  .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_ready(d_ready), .d_err(d_err)
);

// File: tb/cfgio_window_test.sv
`timescale 1ns/1ps
module cfgio_window_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] s_addr = '0;
  logic        s_rd = 1'b0, s_wr = 1'b0;
  logic [3:0]  s_be = '0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        s_ready;
  logic        d_req;
  logic [1:0]  d_type;
  logic [31:0] d_addr;
  logic [3:0]  d_be;
  logic [31:0] d_wdata;
  logic        d_ready = 1'b0, d_err = 1'b0;
  logic [31:0] d_rdata = '0;

  int checks = 0, errors = 0, starts = 0;
  bit prev_req = 1'b0, finished = 1'b0;
  // reference model state
  logic [31:0] m_latch = '0;
  bit          exp_valid = 1'b0;
  logic [1:0]  exp_type;
  logic [31:0] exp_addr, exp_wd;
  logic [3:0]  exp_be;

  always #5 clk = ~clk;

  cfgio_window uut (
    .clk(clk), .rst(rst), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr), .s_be(s_be),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ready(s_ready), .d_req(d_req),
    .d_type(d_type), .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata),
    .d_ready(d_ready), .d_err(d_err), .d_rdata(d_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every clock: downstream fields against the model; count cycle starts (R2 R3 R4 R5 R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (d_req && !prev_req) starts++;
      if (d_req) begin
        if (!exp_valid || d_type !== exp_type || d_addr !== exp_addr ||
            d_be !== exp_be || (d_type[0] && d_wdata !== exp_wd)) begin
          errors++;
          $display("FAIL R2-type/R5 downstream: actual t=%0d a=%h be=%h w=%h expected t=%0d a=%h be=%h w=%h",
                   d_type, d_addr, d_be, d_wdata, exp_type, exp_addr, exp_be, exp_wd);
        end
      end
      prev_req = d_req;
    end
  end

  task automatic access(input logic wr, input logic [11:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input int dly, input logic err,
                        input logic [31:0] resp, output logic [31:0] rd);
    bit win, io, done, given;
    int seen, guard;
    logic [1:0] ofs;
    win = (addr[11:2] == 10'h01A) || (addr[11:2] == 10'h01B);
    io  = addr[2];
    ofs = 2'd0;
    for (int i = 3; i >= 0; i--) if (be[i]) ofs = 2'(i);
    if (win) begin
      exp_type = {io, wr};
      exp_addr = io ? {16'h0, m_latch[15:2], ofs} : {m_latch[31:2], ofs};
      exp_be = be; exp_wd = wd; exp_valid = 1'b1;
    end else if (wr && addr[11:2] == 10'h019) begin
      for (int i = 0; i < 4; i++) if (be[i]) m_latch[i*8 +: 8] = wd[i*8 +: 8];
    end
    s_addr = addr; s_be = be; s_wdata = wd; s_wr = wr; s_rd = !wr;
    done = 0; given = 0; seen = 0; guard = 0;
    while (!done) begin
      @(negedge clk);
      d_ready = 1'b0; d_err = 1'b0;
      guard++;
      if (s_ready) begin
        rd = s_rdata; done = 1;
      end else if (d_req) begin
        seen++;
        if (seen == dly) begin
          d_ready = 1'b1; d_err = err; d_rdata = resp; given = 1;
        end
      end
      if (guard > 1000) done = 1;
    end
    s_rd = 1'b0; s_wr = 1'b0; exp_valid = 1'b0;
    check(win ? "R7 stall until ready" : "R10 register ack", 32'(given), 32'(win));
  endtask

  initial begin : main
    logic [31:0] rd;
    int s0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    access(0, 12'h064, 4'hF, 0, 1, 0, 0, rd);
    check("R1 reset latch", rd, 32'h0);
    s0 = starts;
    access(1, 12'h064, 4'hF, 32'h0001_2300, 1, 0, 0, rd);
    access(0, 12'h064, 4'hF, 0, 1, 0, 0, rd);
    check("R1 latch readback", rd, 32'h0001_2300);
    access(1, 12'h064, 4'b0010, 32'h0000_AB00, 1, 0, 0, rd);
    access(0, 12'h064, 4'hF, 0, 1, 0, 0, rd);
    check("R1 partial latch write", rd, 32'h0001_AB00);
    check("R1 no cycle from latch", 32'(starts - s0), 0);

    access(1, 12'h064, 4'hF, 32'h0005_1810, 1, 0, 0, rd);
    s0 = starts;
    access(0, 12'h068, 4'hF, 0, 2, 0, 32'h1234_5678, rd);
    check("R2 config read word", rd, 32'h1234_5678);
    access(0, 12'h068, 4'b0100, 0, 1, 0, 32'hAABB_CCDD, rd);
    check("R5 R6 byte lane 2", rd, 32'h00BB_0000);
    access(0, 12'h06A, 4'b1100, 0, 3, 0, 32'hAABB_CCDD, rd);
    check("R5 R6 upper half", rd, 32'hAABB_0000);
    access(1, 12'h068, 4'b0011, 32'h0000_BEEF, 1, 0, 0, rd);
    check("R3 config write completes, zero data", rd, 32'h0);
    check("R9 one cycle per access", 32'(starts - s0), 4);

    s0 = starts;
    access(1, 12'h064, 4'hF, 32'h0005_1800, 1, 0, 0, rd);
    access(0, 12'h068, 4'hF, 0, 1, 0, 32'h1111_2222, rd);
    access(1, 12'h064, 4'hF, 32'h0005_1804, 1, 0, 0, rd);
    access(0, 12'h068, 4'hF, 0, 1, 0, 32'h3333_4444, rd);
    check("R9 dummy read data", rd, 32'h3333_4444);
    access(1, 12'h068, 4'hF, 32'hCAFE_F00D, 2, 0, 0, rd);
    check("R9 back-to-back count", 32'(starts - s0), 3);

    access(1, 12'h064, 4'hF, 32'hFFFF_03F8, 1, 0, 0, rd);
    access(0, 12'h06C, 4'b0001, 0, 1, 0, 32'h1122_3344, rd);
    check("R4 io byte read", rd, 32'h0000_0044);
    access(1, 12'h06C, 4'b1000, 32'h5A00_0000, 2, 0, 0, rd);
    check("R4 io write completes", rd, 32'h0);

    access(0, 12'h070, 4'hF, 0, 1, 0, 0, rd);
    check("R8 status clear before error", rd, 32'h0);
    access(0, 12'h068, 4'b0001, 0, 2, 1, 32'h0000_0012, rd);
    check("R8 error read all ones", rd, 32'hFFFF_FFFF);
    access(0, 12'h070, 4'hF, 0, 1, 0, 0, rd);
    check("R8 sticky set", rd, 32'h1);
    access(1, 12'h070, 4'hF, 32'h1, 1, 0, 0, rd);
    access(0, 12'h070, 4'hF, 0, 1, 0, 0, rd);
    check("R8 sticky cleared", rd, 32'h0);
    access(1, 12'h06C, 4'hF, 32'h0BAD_0BAD, 1, 1, 0, rd);
    access(0, 12'h070, 4'hF, 0, 1, 0, 0, rd);
    check("R8 write error sets sticky", rd, 32'h1);

    access(0, 12'h068, 4'hF, 0, 20, 0, 32'h7777_8888, rd);
    check("R7 long stall data", rd, 32'h7777_8888);

    s0 = starts;
    access(0, 12'h100, 4'hF, 0, 1, 0, 0, rd);
    check("R10 unused read zero", rd, 32'h0);
    access(1, 12'h100, 4'hF, 32'hDEAD_BEEF, 1, 0, 0, rd);
    access(0, 12'h064, 4'hF, 0, 1, 0, 0, rd);
    check("R10 unused write ignored", rd, m_latch);
    check("R10 no cycle", 32'(starts - s0), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule